// File: doc/BRIEF.md
# Flag-Generating Integer ALU

This block is the arithmetic and logic stage of a small integer datapath that works on byte, word and long operands. It takes a destination operand and a source operand, an operation code and a size code. It returns the size-truncated result at once, together with a store-enable that tells the register stage whether the result should be written back. It also keeps a four-bit condition-code word, which holds the negative, zero, overflow and carry flags.

The result and the store-enable are combinational. The condition-code word is registered. It takes the new flags on a rising clock edge when the input strobe is high and the operation code is a legal one. The stage never stalls and has no back-pressure. Every cycle with the strobe high is one completed operation, so there is no ready signal. Operations that keep the carry flag take it from the registered word, which lets a sequence of operations pass the carry forward.

Top module: `ccflag_alu`

## Requirements
- R1: After an asynchronous active-low reset the condition-code word reads 0000. Its bit order is N in bit 3, Z in bit 2, V in bit 1 and C in bit 0.
- R2: The size code selects the operand width: 0 is byte (8 bits), 1 is word (16 bits), and 2 and 3 are both long (32 bits). Operand bits above the selected size are ignored. The result bits above it read zero.
- R3: Operation code 0 (add) returns dst+src. C is the carry out of the top bit of the selected size.
- R4: Code 1 (subtract) returns dst-src. Code 2 (negate) returns 0-src and ignores dst. For both, C is set when the unsigned src is greater than the unsigned minuend at the selected size (a borrow).
- R5: For add, subtract and negate, the source addend is src for add and the two's complement of src at the selected size for subtract and negate. V is set when this addend and the minuend have equal sign bits and the result's sign bit differs from them.
- R6: Code 3 (compare) produces the same result and flags as subtract, but store-enable stays low.
- R7: Codes 4 (AND), 5 (OR), 6 (XOR) and 7 (move src) clear V and keep C from the registered word.
- R8: Code 8 (increment) returns dst+1 and code 9 (decrement) returns dst-1, and src is ignored. Both keep C. V is set only when an increment starts from the largest positive value at the size, or a decrement starts from the most negative one.
- R9: For every legal code, N is the result's sign bit at the selected size, and Z is set exactly when the size-truncated result is zero.
- R10: The condition-code word changes only on a rising clock edge with the strobe high and a code from 0 to 9. Codes 10 to 15, or a low strobe, leave it unchanged.
- R11: Store-enable is high only while the strobe is high and the code is a legal code other than compare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: the operands and codes this cycle form an operation |
| op_sel | input | 4 | Operation code (0..9 legal) |
| size_sel | input | 2 | Operand size code |
| dst_opnd | input | 32 | Destination / minuend operand |
| src_opnd | input | 32 | Source operand |
| result | output | 32 | Size-truncated result, upper bits zero |
| store_en | output | 1 | Write-back enable for the result |
| cc_word | output | 4 | Registered flags {N, Z, V, C} |

## Verification
The hardest cases to reach from the ports are the operations that keep the carry flag. Their outcome depends on the carry left behind by an earlier operation, so a single isolated vector cannot show a mistake in how the carry is kept. The stimulus table is ordered so that a borrow-producing compare sets C just before the logic operations and the increments and decrements, and each of those vectors expects C still set. Sign-boundary operands (the largest positive value, the most negative value and all-ones) at every size drive the overflow and carry taps. A low strobe and an illegal code are then applied while the flags hold a known non-zero value, so that any unwanted update shows at the ports.

// File: rtl/ccalu_pkg.sv
package ccalu_pkg;

  localparam int unsigned ALU_W  = 32;
  localparam int unsigned LANES  = 3;
  localparam int unsigned LANE_IW = $clog2(LANES);
  localparam int unsigned CC_W   = 4;
  localparam int unsigned CC_N   = 3;
  localparam int unsigned CC_Z   = 2;
  localparam int unsigned CC_V   = 1;
  localparam int unsigned CC_C   = 0;
  localparam int unsigned OP_LAST = 9;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_NEG = 4'd2,
    OP_CMP = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_MOV = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LALT = 2'd3
  } alu_size_e;

  // Lane index for a size code; both long encodings share the widest lane.
  function automatic logic [LANE_IW-1:0] lane_of(input alu_size_e s);
    case (s)
      SZ_BYTE: lane_of = LANE_IW'(0);
      SZ_WORD: lane_of = LANE_IW'(1);
      default: lane_of = LANE_IW'(LANES - 1);
    endcase
  endfunction

  // Width of lane k: 8, 16, ... with the last lane always the full width.
  function automatic int unsigned lane_width(input int unsigned k);
    lane_width = (k == LANES - 1) ? ALU_W : (8 << k);
  endfunction

endpackage

// File: rtl/ccalu_addsub.sv
module ccalu_addsub
  import ccalu_pkg::*;
#(
  parameter int unsigned W  = ALU_W,
  parameter int unsigned NL = LANES
) (
  input  logic                  subtract,
  input  logic [W-1:0]          a_in,
  input  logic [W-1:0]          b_in,
  output logic [NL-1:0][W-1:0]  lane_sum,
  output logic [NL-1:0]         lane_cy,
  output logic [NL-1:0]         lane_ov
);

  // One adder per operand size; the caller picks the lane it needs.
  for (genvar k = 0; k < NL; k++) begin : g_lane
    localparam int unsigned LW = lane_width(k);

    logic [LW:0] raw;
    logic        sgn_a;
    logic        sgn_b;
    logic        sgn_r;

    assign raw = subtract ? ({1'b0, a_in[LW-1:0]} - {1'b0, b_in[LW-1:0]})
                          : ({1'b0, a_in[LW-1:0]} + {1'b0, b_in[LW-1:0]});

    // Sign of the second addend: b itself, or its two's complement at LW bits.
    assign sgn_a = a_in[LW-1];
    assign sgn_b = subtract ? (b_in[LW-1] ^ (|b_in[LW-2:0])) : b_in[LW-1];
    assign sgn_r = raw[LW-1];

    assign lane_sum[k] = W'(raw[LW-1:0]);
    assign lane_cy[k]  = raw[LW];
    assign lane_ov[k]  = (sgn_a == sgn_b) && (sgn_r != sgn_a);
  end

endmodule

// File: rtl/ccalu_logic.sv
module ccalu_logic
  import ccalu_pkg::*;
#(
  parameter int unsigned W = ALU_W
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] size_mask,
  output logic [W-1:0] res
);

  logic [W-1:0] full;

  always_comb begin
    case (op)
      OP_OR:   full = a_in | b_in;
      OP_XOR:  full = a_in ^ b_in;
      OP_MOV:  full = b_in;
      default: full = a_in & b_in;
    endcase
  end

  assign res = full & size_mask;

endmodule

// File: rtl/ccalu_ccreg.sv
module ccalu_ccreg
  import ccalu_pkg::*;
#(
  parameter int unsigned W = CC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] cc_d,
  output logic [W-1:0] cc_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cc_q <= '0;
    else if (load) cc_q <= cc_d;
  end

  // R10: without a load the flag word holds its value.
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cc_q));

  // R10: a load captures the presented flags.
  assert_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cc_q == $past(cc_d)));

endmodule

// File: rtl/ccflag_alu.sv
module ccflag_alu
  import ccalu_pkg::*;
#(
  parameter int unsigned DATA_W = ALU_W,
  parameter int unsigned NLANE  = LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        op_sel,
  input  logic [1:0]        size_sel,
  input  logic [DATA_W-1:0] dst_opnd,
  input  logic [DATA_W-1:0] src_opnd,
  output logic [DATA_W-1:0] result,
  output logic              store_en,
  output logic [CC_W-1:0]   cc_word
);

  alu_op_e                       op;
  alu_size_e                     sz;
  logic [LANE_IW-1:0]            lane;
  logic [NLANE-1:0][DATA_W-1:0]  masks;
  logic [NLANE-1:0]              signs;
  logic                          legal;
  logic                          is_sub;
  logic                          is_step;
  logic [DATA_W-1:0]             a_sel;
  logic [DATA_W-1:0]             b_sel;
  logic [NLANE-1:0][DATA_W-1:0]  lane_sum;
  logic [NLANE-1:0]              lane_cy;
  logic [NLANE-1:0]              lane_ov;
  logic [DATA_W-1:0]             logic_res;
  logic                          flag_n;
  logic                          flag_z;
  logic                          flag_v;
  logic                          flag_c;
  logic [CC_W-1:0]               cc_next;

  assign op    = alu_op_e'(op_sel);
  assign sz    = alu_size_e'(size_sel);
  assign lane  = lane_of(sz);
  assign legal = (op_sel <= 4'(OP_LAST));

  // Per-size mask and sign tap of the chosen result.
  for (genvar k = 0; k < NLANE; k++) begin : g_size
    localparam int unsigned LW = lane_width(k);
    assign masks[k] = DATA_W'({LW{1'b1}});
    assign signs[k] = result[LW-1];
  end

  // Operand steering for the shared adder.
  assign is_step = (op == OP_INC) || (op == OP_DEC);
  assign is_sub  = (op == OP_SUB) || (op == OP_NEG) || (op == OP_CMP) || (op == OP_DEC);
  assign a_sel   = (op == OP_NEG) ? '0 : dst_opnd;
  assign b_sel   = is_step ? DATA_W'(1) : src_opnd;

  ccalu_addsub #(.W(DATA_W), .NL(NLANE)) u_addsub (
    .subtract (is_sub),
    .a_in     (a_sel),
    .b_in     (b_sel),
    .lane_sum (lane_sum),
    .lane_cy  (lane_cy),
    .lane_ov  (lane_ov)
  );

  ccalu_logic #(.W(DATA_W)) u_logic (
    .op        (op),
    .a_in      (dst_opnd),
    .b_in      (src_opnd),
    .size_mask (masks[lane]),
    .res       (logic_res)
  );

  // Result select and flag rules per operation class.
  always_comb begin
    result = '0;
    flag_v = 1'b0;
    flag_c = cc_word[CC_C];
    case (op)
      OP_ADD, OP_SUB, OP_NEG, OP_CMP: begin
        result = lane_sum[lane];
        flag_v = lane_ov[lane];
        flag_c = lane_cy[lane];
      end
      OP_AND, OP_OR, OP_XOR, OP_MOV: begin
        result = logic_res;
      end
      OP_INC, OP_DEC: begin
        result = lane_sum[lane];
        flag_v = lane_ov[lane];
      end
      default: begin
        result = '0;
      end
    endcase
  end

  assign flag_n  = signs[lane];
  assign flag_z  = (result == '0);
  assign cc_next = {flag_n, flag_z, flag_v, flag_c};

  assign store_en = in_valid && legal && (op != OP_CMP);

  ccalu_ccreg #(.W(CC_W)) u_ccreg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (in_valid && legal),
    .cc_d  (cc_next),
    .cc_q  (cc_word)
  );

  // R6: a compare never requests write-back.
  assert_cmp_nostore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'(OP_CMP)) |-> !store_en);

  // R2: a byte result never carries bits above bit 7.
  assert_byte_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (size_sel == 2'(SZ_BYTE)) |-> (result[DATA_W-1:8] == '0));

  // R8: a byte increment from the largest positive value sets V.
  assert_inc_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 4'(OP_INC) && size_sel == 2'(SZ_BYTE) && dst_opnd[7:0] == 8'h7f)
    |=> cc_word[CC_V]);

  // R7: logic operations and moves keep the registered carry.
  assert_keep_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel >= 4'(OP_AND) && op_sel <= 4'(OP_MOV))
    |=> (cc_word[CC_C] == $past(cc_word[CC_C])));

  // R9: the registered Z flag matches the presented result.
  assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legal) |=> (cc_word[CC_Z] == ($past(result) == '0)));

endmodule

// File: tb/sim_ccflag_alu.sv
`timescale 1ns/100ps
module sim_ccflag_alu;

  localparam int NV = 22;
  // {op[3:0], size[1:0], dst[31:0], src[31:0], result[31:0], store, cc[3:0]}
  localparam logic [106:0] VEC [NV] = '{
    {4'd0, 2'd0, 32'h0000_007F, 32'h0000_0001, 32'h0000_0080, 1'b1, 4'b1010},
    {4'd0, 2'd0, 32'h0000_00FF, 32'h0000_0001, 32'h0000_0000, 1'b1, 4'b0101},
    {4'd0, 2'd1, 32'h1234_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 4'b0101},
    {4'd0, 2'd2, 32'hFFFF_FFFF, 32'h0000_0002, 32'h0000_0001, 1'b1, 4'b0001},
    {4'd1, 2'd0, 32'h0000_0005, 32'h0000_0003, 32'h0000_0002, 1'b1, 4'b0000},
    {4'd1, 2'd0, 32'h0000_0003, 32'h0000_0005, 32'h0000_00FE, 1'b1, 4'b1001},
    {4'd1, 2'd1, 32'h0000_8000, 32'h0000_0001, 32'h0000_7FFF, 1'b1, 4'b0010},
    {4'd2, 2'd0, 32'h0000_00AA, 32'h0000_0001, 32'h0000_00FF, 1'b1, 4'b1001},
    {4'd2, 2'd0, 32'h0000_0000, 32'h0000_0080, 32'h0000_0080, 1'b1, 4'b1001},
    {4'd3, 2'd2, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 1'b0, 4'b0100},
    {4'd3, 2'd2, 32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 4'b1001},
    {4'd4, 2'd1, 32'hFFFF_F0F0, 32'h0000_8F00, 32'h0000_8000, 1'b1, 4'b1001},
    {4'd5, 2'd0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b1, 4'b0101},
    {4'd6, 2'd2, 32'hFFFF_0000, 32'h0F0F_0F0F, 32'hF0F0_0F0F, 1'b1, 4'b1001},
    {4'd7, 2'd0, 32'hDEAD_BEEF, 32'h1234_5600, 32'h0000_0000, 1'b1, 4'b0101},
    {4'd8, 2'd0, 32'h0000_007F, 32'h0000_0000, 32'h0000_0080, 1'b1, 4'b1011},
    {4'd8, 2'd1, 32'h0000_FFFF, 32'h0000_0000, 32'h0000_0000, 1'b1, 4'b0101},
    {4'd9, 2'd2, 32'h8000_0000, 32'h0000_0000, 32'h7FFF_FFFF, 1'b1, 4'b0011},
    {4'd9, 2'd0, 32'h0000_0000, 32'h0000_0000, 32'h0000_00FF, 1'b1, 4'b1001},
    {4'd0, 2'd3, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b1, 4'b1010},
    {4'd1, 2'd2, 32'h0000_0001, 32'h0000_0002, 32'hFFFF_FFFF, 1'b1, 4'b1001},
    {4'd0, 2'd1, 32'h0000_8000, 32'h0000_8000, 32'h0000_0000, 1'b1, 4'b0111}
  };
  localparam string TAG [NV] = '{
    "R5", "R3", "R2", "R3", "R4", "R4", "R5", "R4", "R5", "R6", "R6",
    "R7", "R9", "R7", "R7", "R8", "R8", "R8", "R8", "R2", "R4", "R5"
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [1:0]  size_sel = '0;
  logic [31:0] dst_opnd = '0;
  logic [31:0] src_opnd = '0;
  logic [31:0] result;
  logic        store_en;
  logic [3:0]  cc_word;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ccflag_alu u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .op_sel   (op_sel),
    .size_sel (size_sel),
    .dst_opnd (dst_opnd),
    .src_opnd (src_opnd),
    .result   (result),
    .store_en (store_en),
    .cc_word  (cc_word)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [3:0] o, input logic [1:0] s,
                       input logic [31:0] d, input logic [31:0] x);
    @(negedge clk);
    in_valid = v; op_sel = o; size_sel = s; dst_opnd = d; src_opnd = x;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: flags cleared by reset
    chk("R1 reset cc", 32'(cc_word), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cc after release", 32'(cc_word), 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][106:103], VEC[i][102:101], VEC[i][100:69], VEC[i][68:37]);
      chk({TAG[i], " result"}, result, VEC[i][36:5]);
      chk({TAG[i], " store"}, 32'(store_en), 32'(VEC[i][4]));
      @(negedge clk);
      chk({TAG[i], " cc"}, 32'(cc_word), 32'(VEC[i][3:0]));
    end

    // R10 / R11: low strobe changes nothing and requests no store (cc is 0111)
    drive(1'b0, 4'd0, 2'd0, 32'h7F, 32'h1);
    chk("R11 store with strobe low", 32'(store_en), 32'h0);
    @(negedge clk);
    chk("R10 cc held, strobe low", 32'(cc_word), 32'h7);

    // R10 / R11: illegal code with strobe high
    drive(1'b1, 4'd12, 2'd2, 32'h0, 32'h0);
    chk("R11 store on illegal code", 32'(store_en), 32'h0);
    @(negedge clk);
    chk("R10 cc held, illegal code", 32'(cc_word), 32'h7);

    // R1: reset in mid-run clears the flags
    drive(1'b0, 4'd0, 2'd0, 32'h0, 32'h0);
    rst_n = 1'b0;
    #1;
    chk("R1 cc on reset", 32'(cc_word), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cc after second release", 32'(cc_word), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule